// File: doc/BRIEF.md
# Converter Front-End Power Sequencer

This controller owns the three enable lines that power an analog converter front end: two reference/bandgap enables and one core enable. Software asks for a power level through a single write port and may also choose between the internal and an external reference. The controller checks the request, drives the enables, and holds conversion starts back until the analog circuits have had time to settle.

Two settling delays are counted in clock cycles, and both are derived from the clock frequency parameter. A long delay applies whenever the bandgap has not yet settled. A short delay applies when only the core was switched off and the bandgap and reference stayed powered and settled. The reference choice can only change while the bandgap is off. Powering down takes effect at once. Requests with a reserved code are refused and recorded in a sticky flag. Conversion requests made before the block is ready are dropped and recorded in a second sticky flag.

Top module: `adc_pwr_seq`

## Requirements
- R1: A write carries the level `wr_level` = {bgref_en[1], bgref_en[0], core_en}. The code 3'b111 means fully on, 3'b110 means core down with bandgap and reference on, and 3'b000 means off. An accepted write that changes the level drives all three enables to the new code together, at the clock edge that samples the write.
- R2: Any code whose two upper bits differ (3'b01x or 3'b10x) is reserved. Such a write leaves the enables, the reference select and the timing unchanged, and sets `reserved_err`, which stays set until reset.
- R3: After reset, `bgref_en`, `core_en`, `ext_ref_sel`, `ready`, `conv_start`, `reserved_err` and `conv_blocked` are all 0.
- R4: `ext_ref_sel` takes the value of `wr_ext_ref` from a non-reserved write only while `bgref_en` is 2'b00. This includes the write that turns the bandgap on. While `bgref_en` is non-zero, writes do not change it.
- R5: When the bandgap was off, `ready` rises exactly FULL_CYC = CLK_HZ*FULL_US/1e6 clock edges after the edge at which the enables become 3'b111.
- R6: Going from 3'b110 to 3'b111 with a settled bandgap makes `ready` rise exactly CORE_CYC = CLK_HZ*CORE_US/1e6 edges after the enables change.
- R7: A write of 3'b110 or 3'b000 clears `ready` at the same edge that changes the enables, with no delay.
- R8: A level change during a settling delay restarts timing from the new state. If 3'b110 is entered before the bandgap has settled, a following write of 3'b111 waits the full FULL_CYC from that write.
- R9: A write of the level already in force changes neither the enables, the timing nor `ready`.
- R10: While `ready` is 1, a `conv_req` pulse produces a one-cycle `conv_start` at the next edge.
- R11: A `conv_req` while `ready` is 0 produces no `conv_start` and sets `conv_blocked`, which stays set until reset.
- R12: The bandgap also settles while the block sits in 3'b110. Once FULL_CYC edges have passed since the bandgap turned on, a later 3'b111 needs only CORE_CYC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Power-level write strobe |
| wr_level | input | 3 | Requested level {bgref[1], bgref[0], core} |
| wr_ext_ref | input | 1 | Requested reference source (1 = external) |
| conv_req | input | 1 | Conversion start request |
| bgref_en | output | 2 | Reference/bandgap enables |
| core_en | output | 1 | Converter core enable |
| ext_ref_sel | output | 1 | Reference source in force |
| ready | output | 1 | Settled, conversions allowed |
| conv_start | output | 1 | Gated conversion start pulse |
| reserved_err | output | 1 | Sticky flag for a refused reserved write |
| conv_blocked | output | 1 | Sticky flag for a dropped conversion request |

## Verification
The bench builds the block with CLK_HZ = 1,000,000, FULL_US = 5000 and CORE_US = 20. These values give a 5000-cycle full delay and a 20-cycle core delay. Both can be counted edge by edge several times within the run, and checks are placed one edge before and at the expected rise. The 250-to-1 ratio between the two delays means that taking the wrong delay path cannot be mistaken for an off-by-one error. This covers the restart case and the case where the bandgap settles while the core is down.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  localparam logic [2:0] LVL_OFF  = 3'b000;
  localparam logic [2:0] LVL_CDN  = 3'b110;
  localparam logic [2:0] LVL_ON   = 3'b111;

  typedef enum logic [2:0] {
    CMD_HOLD  = 3'd0,
    CMD_OFF   = 3'd1,
    CMD_PAUSE = 3'd2,
    CMD_FULL  = 3'd3,
    CMD_CORE  = 3'd4
  } tmr_cmd_e;

  function automatic logic lvl_reserved(input logic [2:0] code);
    return code[2] ^ code[1];
  endfunction

endpackage

// File: rtl/adc_pwr_decode.sv
module adc_pwr_decode
  import adc_pwr_pkg::*;
(
  input  logic       wr_en,
  input  logic [2:0] wr_level,
  input  logic [2:0] cur_level,
  input  logic       bg_settled,
  output logic       accept,
  output logic       reserved_hit,
  output tmr_cmd_e   cmd
);

  always_comb begin
    reserved_hit = wr_en && lvl_reserved(wr_level);
    accept       = wr_en && !lvl_reserved(wr_level) && (wr_level != cur_level);
    cmd          = CMD_HOLD;
    if (accept) begin
      if (wr_level[2:1] == 2'b00)
        cmd = CMD_OFF;
      else if (bg_settled)
        cmd = wr_level[0] ? CMD_CORE : CMD_PAUSE;
      else
        cmd = CMD_FULL;
    end
  end

endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer
  import adc_pwr_pkg::*;
#(
  parameter int FULL_CYC = 5000,
  parameter int CORE_CYC = 20,
  localparam int MAX_CYC = (FULL_CYC > CORE_CYC) ? FULL_CYC : CORE_CYC,
  localparam int CW      = $clog2(MAX_CYC + 1)
) (
  input  logic     clk,
  input  logic     rst,
  input  tmr_cmd_e cmd,
  output logic     done,
  output logic     settled
);

  logic [CW-1:0] cnt_q;
  logic          settled_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      settled_q <= 1'b0;
    end else begin
      case (cmd)
        CMD_OFF: begin
          cnt_q     <= '0;
          settled_q <= 1'b0;
        end
        CMD_PAUSE: cnt_q <= '0;
        CMD_FULL: begin
          cnt_q     <= CW'(FULL_CYC);
          settled_q <= 1'b0;
        end
        CMD_CORE: cnt_q <= CW'(CORE_CYC);
        default: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) settled_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign done    = (cmd == CMD_HOLD) && (cnt_q == CW'(1));
  assign settled = settled_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAX_CYC)); // R8

  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_FULL) |=> (cnt_q == CW'(FULL_CYC)) && !settled_q); // R8

endmodule

// File: rtl/adc_pwr_gate.sv
module adc_pwr_gate (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic done,
  input  logic lvl_on,
  input  logic conv_req,
  output logic ready,
  output logic conv_start,
  output logic conv_blocked
);

  logic ready_q, start_q, blocked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      start_q   <= 1'b0;
      blocked_q <= 1'b0;
    end else begin
      if (restart)
        ready_q <= 1'b0;
      else if (done && lvl_on)
        ready_q <= 1'b1;
      start_q <= conv_req && ready_q;
      if (conv_req && !ready_q) blocked_q <= 1'b1;
    end
  end

  assign ready        = ready_q;
  assign conv_start   = start_q;
  assign conv_blocked = blocked_q;

  AST_BLOCKED_STICKY: assert property (@(posedge clk) disable iff (rst)
    blocked_q |=> blocked_q); // R11

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start_q && !$past(conv_req) |-> 1'b0); // R10

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int FULL_US = 5000,
  parameter int CORE_US = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_level,
  input  logic       wr_ext_ref,
  input  logic       conv_req,
  output logic [1:0] bgref_en,
  output logic       core_en,
  output logic       ext_ref_sel,
  output logic       ready,
  output logic       conv_start,
  output logic       reserved_err,
  output logic       conv_blocked
);

  localparam logic [63:0] FULL_PROD = 64'(CLK_HZ) * 64'(FULL_US);
  localparam logic [63:0] CORE_PROD = 64'(CLK_HZ) * 64'(CORE_US);
  localparam int FULL_RAW = int'(FULL_PROD / 64'd1_000_000);
  localparam int CORE_RAW = int'(CORE_PROD / 64'd1_000_000);
  localparam int FULL_CYC = (FULL_RAW < 1) ? 1 : FULL_RAW;
  localparam int CORE_CYC = (CORE_RAW < 1) ? 1 : CORE_RAW;

  logic [2:0] lvl_q;
  logic       ext_q, rerr_q;
  logic       accept, reserved_hit, tmr_done, bg_settled;
  tmr_cmd_e   cmd;

  adc_pwr_decode u_dec (
    .wr_en       (wr_en),
    .wr_level    (wr_level),
    .cur_level   (lvl_q),
    .bg_settled  (bg_settled),
    .accept      (accept),
    .reserved_hit(reserved_hit),
    .cmd         (cmd)
  );

  adc_pwr_timer #(
    .FULL_CYC(FULL_CYC),
    .CORE_CYC(CORE_CYC)
  ) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .done   (tmr_done),
    .settled(bg_settled)
  );

  adc_pwr_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .restart     (cmd != CMD_HOLD),
    .done        (tmr_done),
    .lvl_on      (lvl_q == LVL_ON),
    .conv_req    (conv_req),
    .ready       (ready),
    .conv_start  (conv_start),
    .conv_blocked(conv_blocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= LVL_OFF;
      ext_q  <= 1'b0;
      rerr_q <= 1'b0;
    end else begin
      if (accept) lvl_q <= wr_level;
      if (wr_en && !reserved_hit && (lvl_q[2:1] == 2'b00)) ext_q <= wr_ext_ref;
      if (reserved_hit) rerr_q <= 1'b1;
    end
  end

  assign bgref_en     = lvl_q[2:1];
  assign core_en      = lvl_q[0];
  assign ext_ref_sel  = ext_q;
  assign reserved_err = rerr_q;

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_en && lvl_reserved(wr_level) |=> $stable({bgref_en, core_en, ext_ref_sel})); // R2

  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (rst)
    wr_en && lvl_reserved(wr_level) |=> reserved_err); // R2

  AST_EXT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (bgref_en != 2'b00) |=> $stable(ext_ref_sel)); // R4

  AST_READY_FULL_ONLY: assert property (@(posedge clk) disable iff (rst)
    ready |-> (bgref_en == 2'b11) && core_en); // R7

  AST_READY_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> bg_settled); // R5

  AST_CONV_GATED: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(ready && conv_req)); // R10

endmodule

// File: tb/sim_adc_pwr_seq.sv
module sim_adc_pwr_seq;

  localparam int FULL_N = 5000;
  localparam int CORE_N = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_level = 3'b000;
  logic       wr_ext_ref = 1'b0;
  logic       conv_req = 1'b0;
  logic [1:0] bgref_en;
  logic       core_en, ext_ref_sel, ready, conv_start, reserved_err, conv_blocked;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  adc_pwr_seq #(.CLK_HZ(1_000_000), .FULL_US(5000), .CORE_US(20)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_level(wr_level),
    .wr_ext_ref(wr_ext_ref), .conv_req(conv_req), .bgref_en(bgref_en),
    .core_en(core_en), .ext_ref_sel(ext_ref_sel), .ready(ready),
    .conv_start(conv_start), .reserved_err(reserved_err),
    .conv_blocked(conv_blocked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_lvl(input logic [2:0] lvl, input logic ext);
    @(negedge clk);
    wr_en = 1'b1; wr_level = lvl; wr_ext_ref = ext;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_conv();
    @(negedge clk);
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R3 enables", {29'd0, bgref_en, core_en}, 32'd0);
    check("R3 ready/start", {30'd0, ready, conv_start}, 32'd0);
    check("R3 flags/ext", {29'd0, ext_ref_sel, reserved_err, conv_blocked}, 32'd0);
  endtask

  task automatic t_blocked();
    pulse_conv();
    check("R11 no start", {31'd0, conv_start}, 32'd0);
    check("R11 blocked flag", {31'd0, conv_blocked}, 32'd1);
    wait_n(3);
    check("R11 sticky", {31'd0, conv_blocked}, 32'd1);
  endtask

  task automatic t_full_up();
    write_lvl(3'b000, 1'b1);
    check("R4 ext captured while off", {31'd0, ext_ref_sel}, 32'd1);
    check("R9 same level no change", {29'd0, bgref_en, core_en}, 32'd0);
    write_lvl(3'b111, 1'b1);
    check("R1 all enables together", {29'd0, bgref_en, core_en}, 32'h7);
    check("R5 not ready at start", {31'd0, ready}, 32'd0);
    wait_n(FULL_N - 1);
    check("R5 not ready one edge early", {31'd0, ready}, 32'd0);
    wait_n(1);
    check("R5 ready after full delay", {31'd0, ready}, 32'd1);
    write_lvl(3'b111, 1'b0);
    check("R4 ext frozen while bandgap on", {31'd0, ext_ref_sel}, 32'd1);
    check("R9 ready kept on same-level write", {31'd0, ready}, 32'd1);
  endtask

  task automatic t_conv();
    @(negedge clk);
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    check("R10 start pulse", {31'd0, conv_start}, 32'd1);
    @(negedge clk);
    check("R10 single cycle", {31'd0, conv_start}, 32'd0);
  endtask

  task automatic t_reserved();
    write_lvl(3'b101, 1'b0);
    check("R2 enables kept (101)", {29'd0, bgref_en, core_en}, 32'h7);
    check("R2 flag set", {31'd0, reserved_err}, 32'd1);
    check("R2 ready kept", {31'd0, ready}, 32'd1);
    write_lvl(3'b010, 1'b0);
    check("R2 enables kept (010)", {29'd0, bgref_en, core_en}, 32'h7);
    check("R2 ext kept", {31'd0, ext_ref_sel}, 32'd1);
  endtask

  task automatic t_core_cycle();
    write_lvl(3'b110, 1'b0);
    check("R7 core off immediately", {29'd0, bgref_en, core_en}, 32'h6);
    check("R7 ready cleared", {31'd0, ready}, 32'd0);
    write_lvl(3'b111, 1'b0);
    wait_n(CORE_N - 1);
    check("R6 not ready one edge early", {31'd0, ready}, 32'd0);
    wait_n(1);
    check("R6 ready after core delay", {31'd0, ready}, 32'd1);
  endtask

  task automatic t_off();
    write_lvl(3'b000, 1'b0);
    check("R7 all off immediately", {29'd0, bgref_en, core_en}, 32'd0);
    check("R7 ready cleared at off", {31'd0, ready}, 32'd0);
    write_lvl(3'b000, 1'b0);
    check("R4 ext changeable when off", {31'd0, ext_ref_sel}, 32'd0);
  endtask

  task automatic t_restart();
    write_lvl(3'b111, 1'b0);
    wait_n(100);
    write_lvl(3'b110, 1'b0);
    write_lvl(3'b111, 1'b0);
    wait_n(CORE_N);
    check("R8 unsettled: no short delay", {31'd0, ready}, 32'd0);
    wait_n(FULL_N - CORE_N - 1);
    check("R8 not ready one edge early", {31'd0, ready}, 32'd0);
    wait_n(1);
    check("R8 ready full delay after restart", {31'd0, ready}, 32'd1);
  endtask

  task automatic t_settle_in_cdn();
    write_lvl(3'b000, 1'b0);
    write_lvl(3'b110, 1'b0);
    wait_n(FULL_N + 5);
    check("R12 not ready while core down", {31'd0, ready}, 32'd0);
    write_lvl(3'b111, 1'b0);
    wait_n(CORE_N - 1);
    check("R12 not ready one edge early", {31'd0, ready}, 32'd0);
    wait_n(1);
    check("R12 ready after core delay", {31'd0, ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_blocked();
    t_full_up();
    t_conv();
    t_reserved();
    t_core_cycle();
    t_off();
    t_restart();
    t_settle_in_cdn();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule